// File: doc/BRIEF.md
# Bus Arrival Announcement Sequencer

This block runs a station's arrival announcements. A radio decoder raises a valid-transmission strobe whenever a bus code arrives. The sequencer takes the 4-bit code on the rising edge of that strobe. It recognises four one-hot codes, each naming a bus and a direction. For a recognised code it fires a short trigger pulse on the matching message-select line of a voice playback device. It also shows the matching entry on a display-slot index.

After the trigger, the sequencer waits for the playback device to report that it is ready again. It then falls back to the welcome state, where the display index is 0. Strobes that arrive while an announcement is in progress have no effect. Codes that are not recognised are dropped. A timeout brings the sequencer back to idle if the playback device never reports ready.

Top module: `bus_announce_seq`

## Requirements
- R1: Out of idle, a code is accepted only on a rising edge of `strobe_i` (low in the previous cycle, high in this one). `code_i` is sampled in that same cycle.
- R2: The code map is as follows. 4'b0001 drives `sel_o[0]` and sets slot 1. 4'b0010 drives `sel_o[1]` and sets slot 2. 4'b0100 drives `sel_o[2]` and sets slot 3. 4'b1000 drives `sel_o[3]` and sets slot 4.
- R3: Any code other than these four is ignored, including 4'b0000 and codes with several bits set. In that case `sel_o` stays 0, `slot_o` stays 0 and the state stays idle. A fresh rising edge is then needed to accept a new code.
- R4: After acceptance, only the matching select bit goes high. It stays high for exactly `PULSE_CYC` clock cycles (default 4), starting the cycle after the sampling edge.
- R5: When the pulse ends, the sequencer enters the wait state. It returns to idle on the clock edge where `play_ready_i` is seen high.
- R6: `slot_o` holds the accepted slot from the cycle after acceptance until the return to idle. At that point it goes back to 0 (welcome).
- R7: Strobe edges during the pulse and wait states are ignored. A strobe that is still high on the return to idle must first go low and then high before a new code is accepted.
- R8: If `play_ready_i` stays low, the sequencer spends exactly `TIMEOUT_CYC` cycles in the wait state and then returns to idle.
- R9: `state_o` reports the state: 0 for idle, 1 for pulse, 2 for wait.
- R10: After reset, `state_o` is 0, `sel_o` is 0 and `slot_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Valid-transmission strobe from the decoder |
| code_i | input | 4 | Received bus/direction code |
| play_ready_i | input | 1 | Playback device ready (announcement finished) |
| sel_o | output | 4 | One-shot message-select lines |
| slot_o | output | 3 | Display slot index, 0 means welcome |
| state_o | output | 2 | Sequencer state |

## Verification
The bench sends each of the four valid one-hot codes. This separates the select lines and the slot values from each other, and the pulse width is counted for each code. It also sends a zero code and a multi-bit code, which shows that the one-hot check rejects both an empty pattern and an ambiguous one. Three more patterns separate the strobe edge detection from level sensing and show that the timeout is independent of the ready handshake: a strobe held high across the return to idle, a second strobe edge carrying a different code during the wait, and a run where ready is never given.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2
  } bas_state_e;
endpackage

// File: rtl/bas_code_map.sv
module bas_code_map #(
  parameter int N_SLOTS = 4,
  localparam int SLOT_W = $clog2(N_SLOTS + 1)
) (
  input  logic [N_SLOTS-1:0] code_i,
  output logic               valid_o,
  output logic [SLOT_W-1:0]  slot_o
);
  logic [N_SLOTS-1:0] code_m1;
  assign code_m1 = code_i - N_SLOTS'(1);
  // exactly one bit set
  assign valid_o = (code_i != '0) && ((code_i & code_m1) == '0);

  always_comb begin
    slot_o = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (code_i[i]) slot_o = SLOT_W'(i + 1);
    end
  end
endmodule

// File: rtl/bas_countdown.sv
module bas_countdown #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bus_announce_seq.sv
module bus_announce_seq
  import bas_pkg::*;
#(
  parameter int N_SLOTS     = 4,
  parameter int PULSE_CYC   = 4,
  parameter int TIMEOUT_CYC = 1000,
  localparam int SLOT_W = $clog2(N_SLOTS + 1),
  localparam int PW     = $clog2(PULSE_CYC + 1),
  localparam int TW     = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [N_SLOTS-1:0] code_i,
  input  logic               play_ready_i,
  output logic [N_SLOTS-1:0] sel_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [1:0]         state_o
);
  bas_state_e         state_q, state_d;
  logic               strobe_q, strobe_rise;
  logic               code_valid;
  logic [SLOT_W-1:0]  map_slot;
  logic               pls_load, pls_dec, pls_zero;
  logic               tmo_load, tmo_dec, tmo_zero;
  logic               accept;
  logic [N_SLOTS-1:0] sel_q;
  logic [SLOT_W-1:0]  slot_q;

  bas_code_map #(.N_SLOTS(N_SLOTS)) u_map (
    .code_i (code_i),
    .valid_o(code_valid),
    .slot_o (map_slot)
  );

  bas_countdown #(.W(PW)) u_pulse_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (pls_load),
    .load_val_i(PW'(PULSE_CYC - 1)),
    .dec_i     (pls_dec),
    .zero_o    (pls_zero)
  );

  bas_countdown #(.W(TW)) u_wait_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmo_load),
    .load_val_i(TW'(TIMEOUT_CYC - 1)),
    .dec_i     (tmo_dec),
    .zero_o    (tmo_zero)
  );

  assign strobe_rise = strobe_i & ~strobe_q;
  assign accept      = (state_q == ST_IDLE) && strobe_rise && code_valid;

  always_comb begin
    state_d  = state_q;
    pls_load = 1'b0;
    pls_dec  = 1'b0;
    tmo_load = 1'b0;
    tmo_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = ST_PULSE;
        pls_load = 1'b1;
      end
      ST_PULSE: if (pls_zero) begin
        state_d  = ST_WAIT;
        tmo_load = 1'b1;
      end else begin
        pls_dec = 1'b1;
      end
      ST_WAIT: if (play_ready_i || tmo_zero) begin
        state_d = ST_IDLE;
      end else begin
        tmo_dec = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      strobe_q <= 1'b0;
      sel_q    <= '0;
      slot_q   <= '0;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_i;
      if (accept) begin
        sel_q  <= code_i;
        slot_q <= map_slot;
      end else begin
        if (state_q == ST_PULSE && pls_zero) sel_q <= '0;
        if (state_q == ST_WAIT && state_d == ST_IDLE) slot_q <= '0;
      end
    end
  end

  assign sel_o   = sel_q;
  assign slot_o  = slot_q;
  assign state_o = state_q;

  a_r4_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  a_r4_sel_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != '0) |-> (state_q == ST_PULSE));
  a_r1_no_edge_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !strobe_i) |=> (state_q == ST_IDLE));
  a_r3_bad_code_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !code_valid) |=> (state_q == ST_IDLE && sel_o == '0));
  a_r5_ready_returns_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && play_ready_i) |=> (state_q == ST_IDLE));
  a_r6_idle_slot_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (slot_o == '0));
  a_r6_busy_slot_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (slot_o != '0));
endmodule

// File: tb/sim_bus_announce_seq.sv
module sim_bus_announce_seq;
  localparam int PULSE = 4;
  localparam int TMO   = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [3:0] code = '0;
  logic       ready = 1'b0;
  logic [3:0] sel;
  logic [2:0] slot;
  logic [1:0] state;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  bus_announce_seq #(.N_SLOTS(4), .PULSE_CYC(PULSE), .TIMEOUT_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .code_i(code),
    .play_ready_i(ready), .sel_o(sel), .slot_o(slot), .state_o(state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(state == 2'd0, "R10 state", state, 0);
    chk(sel == 4'd0, "R10 sel", sel, 0);
    chk(slot == 3'd0, "R10 slot", slot, 0);
  endtask

  // accept code, count pulse, hand back ready
  task automatic t_valid(input logic [3:0] c, input int exp_slot, input bit hold_strobe);
    int n;
    @(negedge clk); code = c; strobe = 1'b1;
    @(negedge clk);
    chk(state == 2'd1, "R9 pulse state", state, 1);
    chk(sel == c, "R2 select line", sel, c);
    chk(slot == 3'(exp_slot), "R6 slot shown", slot, exp_slot);
    if (!hold_strobe) strobe = 1'b0;
    n = 1;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (sel != 4'd0) n++; else break;
    end
    chk(n == PULSE, "R4 pulse width", n, PULSE);
    chk(state == 2'd2, "R5 wait state", state, 2);
    repeat (3) @(negedge clk);
    chk(state == 2'd2 && slot == 3'(exp_slot), "R5 holds in wait", state, 2);
    ready = 1'b1;
    @(negedge clk); ready = 1'b0;
    chk(state == 2'd0, "R5 back to idle", state, 0);
    chk(slot == 3'd0, "R6 slot welcome", slot, 0);
  endtask

  task automatic t_invalid(input logic [3:0] c);
    @(negedge clk); code = c; strobe = 1'b1;
    @(negedge clk);
    chk(state == 2'd0, "R3 stays idle", state, 0);
    chk(sel == 4'd0 && slot == 3'd0, "R3 no select", sel, 0);
    code = 4'b0001;
    @(negedge clk);
    chk(state == 2'd0, "R3 needs new edge", state, 0);
    strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_held_strobe();
    t_valid(4'b0100, 3, 1'b1);
    code = 4'b1000;
    repeat (3) @(negedge clk);
    chk(state == 2'd0, "R7 held strobe ignored", state, 0);
    strobe = 1'b0;
    @(negedge clk);
    t_valid(4'b1000, 4, 1'b0);
  endtask

  task automatic t_strobe_in_wait();
    @(negedge clk); code = 4'b0010; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    repeat (PULSE + 1) @(negedge clk);
    code = 4'b0100; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    chk(state == 2'd2 && sel == 4'd0, "R7 edge in wait ignored", sel, 0);
    chk(slot == 3'd2, "R7 slot kept", slot, 2);
    ready = 1'b1;
    @(negedge clk); ready = 1'b0;
    chk(state == 2'd0, "R5 idle after ready", state, 0);
  endtask

  task automatic t_timeout();
    int n;
    @(negedge clk); code = 4'b0001; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    repeat (PULSE - 1) @(negedge clk);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (state == 2'd2) n++; else break;
    end
    chk(n == TMO, "R8 timeout length", n, TMO);
    chk(state == 2'd0 && slot == 3'd0, "R8 idle after timeout", state, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_valid(4'b0001, 1, 1'b0);
    t_valid(4'b0010, 2, 1'b0);
    t_valid(4'b0100, 3, 1'b0);
    t_valid(4'b1000, 4, 1'b0);
    t_invalid(4'b0000);
    t_invalid(4'b0110);
    t_invalid(4'b1111);
    t_held_strobe();
    t_strobe_in_wait();
    t_timeout();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule